// File: doc/BRIEF.md
# Translation Fault Diagnostic Capture

This block records diagnostic state when an address translation fault is raised on the data side or the instruction side of a processor, so that a fault handler can later read out what went wrong. On a data fault it keeps the faulting virtual address, a packed status word, and a formatted page-table-entry address. The status word holds the opcode, the first register number and the fault flag bits. On an instruction fault it keeps the faulting fetch address and the matching formatted page-table-entry address.

The formatted addresses come from two page-table base registers held inside the block, one per side, which software loads through a simple write port. Capture is skipped outright for misspeculated accesses, for data requests that are themselves page-table-entry loads, and for data requests marked no-fault. A skipped fault leaves every register untouched. The registers are never locked pending a read. A one-cycle strobe per side marks each real update.

Top module: `xlat_fault_capture`

## Requirements
- R1: After a synchronous active-low reset, every captured register, both base registers and both strobes read zero.
- R2: A data fault with none of its suppress conditions present loads `d_vaddr_q` with `d_vaddr`. The new value is visible from the clock edge that samples the fault.
- R3: On a data capture, `d_stat_q` holds `d_inst[31:26]` in bits 16:11, `d_inst[25:21]` in bits 10:6 and `d_flags[5:0]` in bits 5:0.
- R4: On a data capture, `d_form_q` equals the data base register OR ((`d_vaddr` >> 13) << 3), truncated to 43 bits.
- R5: A data fault presented with any of `d_spec`, `d_pte_load` or `d_no_fault` high changes none of `d_vaddr_q`, `d_stat_q` and `d_form_q`, and `d_cap` stays low.
- R6: An instruction fault with `i_spec` low loads `i_tag_q` with `i_pc`, and loads `i_form_q` with the instruction base register OR ((`i_pc` >> 13) << 3).
- R7: An instruction fault presented with `i_spec` high changes neither `i_tag_q` nor `i_form_q`, and `i_cap` stays low.
- R8: A write with `ptb_wr_sel` = 0 loads the data base register and one with `ptb_wr_sel` = 1 loads the instruction base register. A fault sampled on the same edge as the write still uses the old base value.
- R9: `d_cap` and `i_cap` are high for exactly the one cycle after an edge on which their side captured, and low otherwise.
- R10: The two sides are independent. Faults on both sides at once are both captured, and a fault on one side leaves the other side's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptb_wr_en | input | 1 | Base register write enable |
| ptb_wr_sel | input | 1 | Base register select: 0 data, 1 instruction |
| ptb_wr_data | input | 43 | Base register write value |
| d_fault | input | 1 | Data-side translation fault this cycle |
| d_vaddr | input | 43 | Faulting data virtual address |
| d_inst | input | 32 | Instruction word of the faulting access |
| d_flags | input | 6 | Fault flag bits |
| d_pte_load | input | 1 | Request is a page-table-entry load |
| d_no_fault | input | 1 | Request is marked no-fault |
| d_spec | input | 1 | Data access is misspeculated |
| i_fault | input | 1 | Instruction-side translation fault this cycle |
| i_pc | input | 43 | Faulting fetch address |
| i_spec | input | 1 | Fetch is misspeculated |
| d_vaddr_q | output | 43 | Captured data virtual address |
| d_stat_q | output | 17 | Captured data status word |
| d_form_q | output | 43 | Captured data formatted PTE address |
| d_cap | output | 1 | Data capture strobe |
| i_tag_q | output | 43 | Captured fetch address |
| i_form_q | output | 43 | Captured instruction formatted PTE address |
| i_cap | output | 1 | Instruction capture strobe |

## Verification
The hardest case to reach is a base register write on the same edge as faults on both sides. Here the formatted addresses must use the old base, and each side must stay out of the other's state. The bench drives that single cycle on purpose and then sends a follow-up fault to confirm the new base has taken effect. The suppress conditions are swept through every non-zero combination, each one following a successful capture. This way a register that changed when it should not have shows up as a difference from a value that is known to be nonzero.

// File: rtl/xfc_pkg.sv
// Package: shared defaults and types for the translation fault capture block.
// Assumes 8 KB pages and 8-byte page-table entries unless overridden.
package xfc_pkg;
    localparam int unsigned XFC_VA_W       = 43;
    localparam int unsigned XFC_INST_W     = 32;
    localparam int unsigned XFC_FLAG_W     = 6;
    localparam int unsigned XFC_OPC_LSB    = 26;
    localparam int unsigned XFC_OPC_W      = 6;
    localparam int unsigned XFC_RA_LSB     = 21;
    localparam int unsigned XFC_RA_W       = 5;
    localparam int unsigned XFC_PAGE_SHIFT = 13;
    localparam int unsigned XFC_PTE_SHIFT  = 3;

    // Selects which base register a software write lands in
    typedef enum logic {
        PTB_DATA = 1'b0,
        PTB_INST = 1'b1
    } ptb_sel_e;

    // Conditions under which a data fault must not be recorded
    typedef struct packed {
        logic spec;
        logic pte_load;
        logic no_fault;
    } d_attr_t;
endpackage

// File: rtl/xfc_ptbase_regs.sv
// Module: xfc_ptbase_regs
// Holds the data-side and instruction-side page-table base registers.
// Assumes software writes one register per cycle, selected by wr_sel.
module xfc_ptbase_regs
    import xfc_pkg::*;
#(
    parameter int unsigned VA_W = XFC_VA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  ptb_sel_e        wr_sel,
    input  logic [VA_W-1:0] wr_data,
    output logic [VA_W-1:0] d_base,
    output logic [VA_W-1:0] i_base
);
    // Load the selected base register on a write; clear both on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_base <= '0;
            i_base <= '0;
        end else if (wr_en) begin
            if (wr_sel == PTB_DATA) d_base <= wr_data;
            else                    i_base <= wr_data;
        end
    end

    AST_PTB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(d_base) && $stable(i_base))); // R8
    AST_PTB_DSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PTB_DATA) |=> (d_base == $past(wr_data) && $stable(i_base))); // R8
endmodule

// File: rtl/xfc_pte_former.sv
// Module: xfc_pte_former
// Combinational formatted page-table-entry address: base OR (page number << entry shift).
// Assumes the result is truncated to the address width.
module xfc_pte_former #(
    parameter int unsigned VA_W       = 43,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned PTE_SHIFT  = 3
) (
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] addr,
    output logic [VA_W-1:0] form
);
    logic [VA_W-1:0] page_num;

    // Extract the page number and place it at the entry offset
    always_comb begin
        page_num = addr >> PAGE_SHIFT;
        form     = base | (page_num << PTE_SHIFT);
    end
endmodule

// File: rtl/xfc_dside_capture.sv
// Module: xfc_dside_capture
// Records data-side fault state: address, packed status word, formatted PTE address.
// Assumes opcode and register fields sit at fixed instruction bit positions;
// capture is skipped for misspeculated, page-table-entry and no-fault requests.
module xfc_dside_capture
    import xfc_pkg::*;
#(
    parameter int unsigned VA_W       = XFC_VA_W,
    parameter int unsigned INST_W     = XFC_INST_W,
    parameter int unsigned FLAG_W     = XFC_FLAG_W,
    parameter int unsigned OPC_LSB    = XFC_OPC_LSB,
    parameter int unsigned OPC_W      = XFC_OPC_W,
    parameter int unsigned RA_LSB     = XFC_RA_LSB,
    parameter int unsigned RA_W       = XFC_RA_W,
    parameter int unsigned PAGE_SHIFT = XFC_PAGE_SHIFT,
    parameter int unsigned PTE_SHIFT  = XFC_PTE_SHIFT,
    localparam int unsigned STAT_W    = OPC_W + RA_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [INST_W-1:0] inst,
    input  logic [FLAG_W-1:0] flags,
    input  d_attr_t           attr,
    input  logic [VA_W-1:0]   base,
    output logic [VA_W-1:0]   vaddr_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [VA_W-1:0]   form_q,
    output logic              cap_q
);
    logic              take;
    logic [VA_W-1:0]   form_next;
    logic [STAT_W-1:0] stat_next;

    xfc_pte_former #(
        .VA_W      (VA_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_form (
        .base(base),
        .addr(vaddr),
        .form(form_next)
    );

    // Decide whether this fault is recorded and pack the status word
    always_comb begin
        take      = fault && !(attr.spec || attr.pte_load || attr.no_fault);
        stat_next = {inst[OPC_LSB +: OPC_W], inst[RA_LSB +: RA_W], flags};
    end

    // Capture registers and the one-cycle update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            stat_q  <= '0;
            form_q  <= '0;
            cap_q   <= 1'b0;
        end else begin
            cap_q <= take;
            if (take) begin
                vaddr_q <= vaddr;
                stat_q  <= stat_next;
                form_q  <= form_next;
            end
        end
    end

    AST_D_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cap_q && vaddr_q == $past(vaddr))); // R2
    AST_D_OPC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (stat_q[STAT_W-1 -: OPC_W] == $past(inst[OPC_LSB +: OPC_W]))); // R3
    AST_D_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && (attr.spec || attr.pte_load || attr.no_fault))
            |=> ($stable(vaddr_q) && $stable(stat_q) && $stable(form_q) && !cap_q)); // R5
    AST_D_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> (!cap_q && $stable(vaddr_q) && $stable(form_q))); // R9
endmodule

// File: rtl/xfc_iside_capture.sv
// Module: xfc_iside_capture
// Records instruction-side fault state: fetch address and formatted PTE address.
// Assumes only misspeculation suppresses capture on this side.
module xfc_iside_capture
    import xfc_pkg::*;
#(
    parameter int unsigned VA_W       = XFC_VA_W,
    parameter int unsigned PAGE_SHIFT = XFC_PAGE_SHIFT,
    parameter int unsigned PTE_SHIFT  = XFC_PTE_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault,
    input  logic [VA_W-1:0] pc,
    input  logic            spec,
    input  logic [VA_W-1:0] base,
    output logic [VA_W-1:0] tag_q,
    output logic [VA_W-1:0] form_q,
    output logic            cap_q
);
    logic            take;
    logic [VA_W-1:0] form_next;

    xfc_pte_former #(
        .VA_W      (VA_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_form (
        .base(base),
        .addr(pc),
        .form(form_next)
    );

    // Decide whether this fetch fault is recorded
    always_comb take = fault && !spec;

    // Capture registers and the one-cycle update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            form_q <= '0;
            cap_q  <= 1'b0;
        end else begin
            cap_q <= take;
            if (take) begin
                tag_q  <= pc;
                form_q <= form_next;
            end
        end
    end

    AST_I_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cap_q && tag_q == $past(pc))); // R6
    AST_I_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && spec) |=> ($stable(tag_q) && $stable(form_q) && !cap_q)); // R7
    AST_I_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> (!cap_q && $stable(tag_q))); // R9
endmodule

// File: rtl/xlat_fault_capture.sv
// Module: xlat_fault_capture
// Top: base registers plus independent data-side and instruction-side capture.
// Assumes faults and base writes are single-cycle pulses sampled on the clock edge.
module xlat_fault_capture
    import xfc_pkg::*;
#(
    parameter int unsigned VA_W       = XFC_VA_W,
    parameter int unsigned INST_W     = XFC_INST_W,
    parameter int unsigned FLAG_W     = XFC_FLAG_W,
    parameter int unsigned OPC_LSB    = XFC_OPC_LSB,
    parameter int unsigned OPC_W      = XFC_OPC_W,
    parameter int unsigned RA_LSB     = XFC_RA_LSB,
    parameter int unsigned RA_W       = XFC_RA_W,
    parameter int unsigned PAGE_SHIFT = XFC_PAGE_SHIFT,
    parameter int unsigned PTE_SHIFT  = XFC_PTE_SHIFT,
    localparam int unsigned STAT_W    = OPC_W + RA_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptb_wr_en,
    input  logic              ptb_wr_sel,
    input  logic [VA_W-1:0]   ptb_wr_data,
    input  logic              d_fault,
    input  logic [VA_W-1:0]   d_vaddr,
    input  logic [INST_W-1:0] d_inst,
    input  logic [FLAG_W-1:0] d_flags,
    input  logic              d_pte_load,
    input  logic              d_no_fault,
    input  logic              d_spec,
    input  logic              i_fault,
    input  logic [VA_W-1:0]   i_pc,
    input  logic              i_spec,
    output logic [VA_W-1:0]   d_vaddr_q,
    output logic [STAT_W-1:0] d_stat_q,
    output logic [VA_W-1:0]   d_form_q,
    output logic              d_cap,
    output logic [VA_W-1:0]   i_tag_q,
    output logic [VA_W-1:0]   i_form_q,
    output logic              i_cap
);
    logic [VA_W-1:0] d_base;
    logic [VA_W-1:0] i_base;
    ptb_sel_e        wr_sel;
    d_attr_t         d_attr;

    // Map raw port bits onto the shared types
    always_comb begin
        wr_sel          = ptb_sel_e'(ptb_wr_sel);
        d_attr.spec     = d_spec;
        d_attr.pte_load = d_pte_load;
        d_attr.no_fault = d_no_fault;
    end

    xfc_ptbase_regs #(.VA_W(VA_W)) u_ptb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ptb_wr_en),
        .wr_sel (wr_sel),
        .wr_data(ptb_wr_data),
        .d_base (d_base),
        .i_base (i_base)
    );

    xfc_dside_capture #(
        .VA_W(VA_W), .INST_W(INST_W), .FLAG_W(FLAG_W),
        .OPC_LSB(OPC_LSB), .OPC_W(OPC_W), .RA_LSB(RA_LSB), .RA_W(RA_W),
        .PAGE_SHIFT(PAGE_SHIFT), .PTE_SHIFT(PTE_SHIFT)
    ) u_dside (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault  (d_fault),
        .vaddr  (d_vaddr),
        .inst   (d_inst),
        .flags  (d_flags),
        .attr   (d_attr),
        .base   (d_base),
        .vaddr_q(d_vaddr_q),
        .stat_q (d_stat_q),
        .form_q (d_form_q),
        .cap_q  (d_cap)
    );

    xfc_iside_capture #(
        .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PTE_SHIFT(PTE_SHIFT)
    ) u_iside (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (i_fault),
        .pc    (i_pc),
        .spec  (i_spec),
        .base  (i_base),
        .tag_q (i_tag_q),
        .form_q(i_form_q),
        .cap_q (i_cap)
    );

    AST_SIDE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fault && !i_fault) |=> ($stable(i_tag_q) && $stable(i_form_q))); // R10
endmodule

// File: tb/tb_xlat_fault_capture.sv
`timescale 1ns/1ps
module tb_xlat_fault_capture;
    localparam int VA_W = 43;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ptb_wr_en, ptb_wr_sel;
    logic [VA_W-1:0] ptb_wr_data;
    logic            d_fault, d_pte_load, d_no_fault, d_spec;
    logic [VA_W-1:0] d_vaddr;
    logic [31:0]     d_inst;
    logic [5:0]      d_flags;
    logic            i_fault, i_spec;
    logic [VA_W-1:0] i_pc;
    logic [VA_W-1:0] d_vaddr_q, d_form_q, i_tag_q, i_form_q;
    logic [16:0]     d_stat_q;
    logic            d_cap, i_cap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [VA_W-1:0] e_dbase, e_ibase, e_dva, e_dform, e_itag, e_iform;
    logic [16:0]     e_dstat;

    always #2.5 clk = ~clk;

    xlat_fault_capture dut (
        .clk(clk), .rst_n(rst_n),
        .ptb_wr_en(ptb_wr_en), .ptb_wr_sel(ptb_wr_sel), .ptb_wr_data(ptb_wr_data),
        .d_fault(d_fault), .d_vaddr(d_vaddr), .d_inst(d_inst), .d_flags(d_flags),
        .d_pte_load(d_pte_load), .d_no_fault(d_no_fault), .d_spec(d_spec),
        .i_fault(i_fault), .i_pc(i_pc), .i_spec(i_spec),
        .d_vaddr_q(d_vaddr_q), .d_stat_q(d_stat_q), .d_form_q(d_form_q), .d_cap(d_cap),
        .i_tag_q(i_tag_q), .i_form_q(i_form_q), .i_cap(i_cap)
    );

    function automatic logic [VA_W-1:0] fmt(input logic [VA_W-1:0] b, input logic [VA_W-1:0] a);
        logic [VA_W-1:0] vpn;
        vpn = a / 43'd8192;
        return b | (vpn * 43'd8);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_d(input string req);
        chk({req, " dva"},   64'(d_vaddr_q), 64'(e_dva));
        chk({req, " dstat"}, 64'(d_stat_q),  64'(e_dstat));
        chk({req, " dform"}, 64'(d_form_q),  64'(e_dform));
    endtask

    task automatic check_i(input string req);
        chk({req, " itag"},  64'(i_tag_q),  64'(e_itag));
        chk({req, " iform"}, 64'(i_form_q), 64'(e_iform));
    endtask

    task automatic idle();
        ptb_wr_en = 0; ptb_wr_sel = 0; ptb_wr_data = '0;
        d_fault = 0; d_pte_load = 0; d_no_fault = 0; d_spec = 0;
        d_vaddr = '0; d_inst = '0; d_flags = '0;
        i_fault = 0; i_spec = 0; i_pc = '0;
    endtask

    task automatic wr_base(input logic sel, input logic [VA_W-1:0] v);
        @(negedge clk);
        ptb_wr_en = 1; ptb_wr_sel = sel; ptb_wr_data = v;
        @(negedge clk);
        ptb_wr_en = 0;
        if (sel) e_ibase = v; else e_dbase = v;
    endtask

    // Present one data fault; returns at the negedge after the sampling edge
    task automatic dreq(input logic [VA_W-1:0] va, input logic [31:0] ins,
                        input logic [5:0] fl, input logic pte, input logic nf, input logic sp);
        @(negedge clk);
        d_fault = 1; d_vaddr = va; d_inst = ins; d_flags = fl;
        d_pte_load = pte; d_no_fault = nf; d_spec = sp;
        @(negedge clk);
        d_fault = 0; d_pte_load = 0; d_no_fault = 0; d_spec = 0;
        if (!(pte || nf || sp)) begin
            e_dva   = va;
            e_dstat = {ins[31:26], ins[25:21], fl};
            e_dform = fmt(e_dbase, va);
        end
    endtask

    task automatic ireq(input logic [VA_W-1:0] pc, input logic sp);
        @(negedge clk);
        i_fault = 1; i_pc = pc; i_spec = sp;
        @(negedge clk);
        i_fault = 0; i_spec = 0;
        if (!sp) begin
            e_itag  = pc;
            e_iform = fmt(e_ibase, pc);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        e_dbase = '0; e_ibase = '0; e_dva = '0; e_dform = '0; e_dstat = '0;
        e_itag = '0; e_iform = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check_d("R1");
        check_i("R1");
        chk("R1 dcap", 64'(d_cap), 64'd0);
        chk("R1 icap", 64'(i_cap), 64'd0);

        // R8: load both base registers
        wr_base(1'b0, 43'h5A5_0000_0007);
        wr_base(1'b1, 43'h3C0_0000_0005);

        // R2 R3 R4 R9: sweep every opcode and flag value, varied Ra and addresses
        for (int k = 0; k < 64; k++) begin
            logic [VA_W-1:0] va;
            logic [31:0] ins;
            va  = {11'(k * 37 + 1), 32'(k) * 32'h9E37_79B1};
            ins = {6'(k), 5'(63 - k), 21'(k * 1234)};
            dreq(va, ins, 6'(63 - k), 0, 0, 0);
            chk("R2 dva", 64'(d_vaddr_q), 64'(e_dva));
            chk("R3 dstat", 64'(d_stat_q), 64'(e_dstat));
            chk("R4 dform", 64'(d_form_q), 64'(e_dform));
            chk("R9 dcap high", 64'(d_cap), 64'd1);
            @(negedge clk);
            chk("R9 dcap drops", 64'(d_cap), 64'd0);
        end

        // R5: every non-zero suppress combination after a good capture
        for (int m = 1; m < 8; m++) begin
            dreq(43'h123_4567_89AB + 43'(m), 32'hFFFF_0000 - 32'(m), 6'(m), 0, 0, 0);
            dreq(43'h7FF_FFFF_E000, 32'h1234_5678, 6'h3F, m[0], m[1], m[2]);
            check_d("R5");
            chk("R5 dcap", 64'(d_cap), 64'd0);
        end

        // R6 R10: instruction faults, data side must hold
        for (int k = 0; k < 32; k++) begin
            ireq({11'(k * 91), 32'(k) * 32'h0101_3579}, 0);
            check_i("R6");
            chk("R9 icap", 64'(i_cap), 64'd1);
            check_d("R10");
        end

        // R7: misspeculated fetch
        ireq(43'h0AB_CDEF_0123, 1);
        check_i("R7");
        chk("R7 icap", 64'(i_cap), 64'd0);

        // R8 R10: base write on the same edge as faults on both sides
        @(negedge clk);
        ptb_wr_en = 1; ptb_wr_sel = 0; ptb_wr_data = 43'h000_F000_0000;
        d_fault = 1; d_vaddr = 43'h6543_2100; d_inst = 32'hA4E0_0000; d_flags = 6'h15;
        i_fault = 1; i_pc = 43'h2_2222_4000;
        @(negedge clk);
        idle();
        e_dva = 43'h6543_2100; e_dstat = {6'h29, 5'h07, 6'h15};
        e_dform = fmt(e_dbase, 43'h6543_2100);
        e_itag = 43'h2_2222_4000; e_iform = fmt(e_ibase, 43'h2_2222_4000);
        e_dbase = 43'h000_F000_0000;
        check_d("R8 old base");
        check_i("R10 both");
        chk("R10 dcap", 64'(d_cap), 64'd1);
        chk("R10 icap", 64'(i_cap), 64'd1);
        dreq(43'h6543_2100, 32'h0, 6'h0, 0, 0, 0);
        chk("R8 new base", 64'(d_form_q), 64'(e_dform));

        // R9: quiet cycles with wiggling data inputs change nothing
        @(negedge clk);
        d_vaddr = '1; d_inst = '1; i_pc = '1;
        repeat (2) @(negedge clk);
        check_d("R9 quiet");
        check_i("R9 quiet");
        chk("R9 quiet dcap", 64'(d_cap), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule